// File: doc/BRIEF.md
# Dual-Timing Multiplexed Bus Slave Port

This block is the host-side front end of a small register-and-memory device. It sits on an 8-bit bus that carries the address first and the data second, and it can follow either of two common strobe conventions. A static mode input, `mot_sel`, picks the convention.

With `mot_sel` high, the bus uses a data-strobe style. `ds_pin` is a high-active data strobe, and `rw_pin` gives the direction during that strobe. With `mot_sel` low, the bus uses separate enables. `ds_pin` is a low-active read enable and `rw_pin` is a low-active write enable.

All bus pins are asynchronous to the fast system clock `clk`. They pass through a two-stage synchronizer bank, and every strobe edge is detected in the `clk` domain. A falling address strobe captures a 7-bit location. That location selects one of 128 bytes: 14 clock/control locations followed by 114 user RAM locations.

Toward the register file, the block issues a single-cycle read pulse when a read begins. This ensures that a clear-on-read location is cleared once per access. It issues a single-cycle write pulse when a write strobe ends, together with a per-bit write mask. Read data from the register file is put on `ad_out` while `ad_oe` is high.

Accesses are blocked in three cases: chip select is high, the power-fail input is high, or the host reset input is low.

Top module: `mux_bus_slave`

## Requirements
- R1: A falling edge of `as_strb` captures `ad_in[6:0]` into `reg_addr`. `ad_in[7]` is ignored.
- R2: A rising edge of `as_strb` clears `reg_addr` to 0, whatever the state of `cs_n`.
- R3: Strobe mode (`mot_sel`=1) read. While `cs_n`=0, `rw_pin`=1 and `ds_pin`=1:
  - `ad_oe` is 1 and `ad_out` equals `reg_rdata`.
  - `ad_oe` returns to 0 after `ds_pin` falls.
- R4: Strobe mode write. With `cs_n`=0 and `rw_pin`=0, the falling edge of `ds_pin` produces one `reg_wr` pulse. `reg_wdata` carries the byte that was on `ad_in` during the strobe.
- R5: Enable mode (`mot_sel`=0) read. While `cs_n`=0 and `ds_pin`=0:
  - `ad_oe` is 1 and `ad_out` equals `reg_rdata`.
  - `ad_oe` returns to 0 after `ds_pin` rises.
- R6: Enable mode write. With `cs_n`=0, the rising edge that ends a low pulse on `rw_pin` produces one `reg_wr` pulse carrying the byte held on `ad_in` during the pulse.
- R7: While `cs_n`=1, no `reg_rd`, no `reg_wr` and no `ad_oe` occur. The address is still captured.
- R8: While `pwr_fail`=1, no `reg_rd`, no `reg_wr` and no `ad_oe` occur.
- R9: While `host_rst_n`=0, no `reg_rd`, no `reg_wr` and no `ad_oe` occur.
- R10: Write protection and mask:
  - Writes to locations 12 and 13 produce no `reg_wr`.
  - A write to location 10 carries `reg_wmask`=8'h7F, so bit 7 is read-only.
  - Every other write carries `reg_wmask`=8'hFF.
- R11: `loc_is_ctrl` is 1 for `reg_addr` 0..13. `loc_is_ram` is 1 for `reg_addr` 14..127. Exactly one of the two is 1.
- R12: One read access produces exactly one `reg_rd` pulse, one `clk` cycle wide, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus pins |
| rst_n | input | 1 | Asynchronous system reset, active low |
| mot_sel | input | 1 | Strobe convention: 1 = data strobe with direction, 0 = separate read/write enables |
| host_rst_n | input | 1 | Host reset pin; while low, no access is accepted |
| pwr_fail | input | 1 | Power-fail indication; while high, chip select is forced inactive |
| cs_n | input | 1 | Chip select, active low |
| as_strb | input | 1 | Address strobe |
| ds_pin | input | 1 | Data strobe (mode 1) or read enable, active low (mode 0) |
| rw_pin | input | 1 | Direction (mode 1) or write enable, active low (mode 0) |
| ad_in | input | 8 | Multiplexed address/data bus, inbound |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| reg_addr | output | 7 | Captured location |
| reg_rd | output | 1 | One-cycle read pulse at read start |
| reg_wr | output | 1 | One-cycle write pulse |
| reg_wdata | output | 8 | Write data |
| reg_wmask | output | 8 | Per-bit write enable |
| reg_rdata | input | 8 | Read data from the register file for `reg_addr` |
| loc_is_ctrl | output | 1 | `reg_addr` is a clock/control location |
| loc_is_ram | output | 1 | `reg_addr` is a user RAM location |

## Verification
The assertions check, on every cycle, the properties that do not depend on pin history:
- a read pulse is a single cycle wide and always coincides with the output enable;
- the output enable never appears without an active select;
- no write pulse ever targets a read-only location, and writes to location 10 always carry the masked byte enable;
- once power-fail or a low host reset has persisted past the synchronizer delay, no strobe or enable is active.

Only the bench scenarios can show the ordering behaviours:
- the address clears on the rising strobe;
- write data is taken from the strobe window rather than after it;
- the drive window closes on the correct edge in each mode;
- a select-less cycle still moves the address.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  // Read intent as a level, given the mode and the synchronized pins.
  function automatic logic rd_level(input logic mot, input logic ds, input logic rw);
    return mot ? (ds & rw) : ~ds;
  endfunction

  // Write intent as a level; the write commits when this level ends.
  function automatic logic wr_level(input logic mot, input logic ds, input logic rw);
    return mot ? (ds & ~rw) : ~rw;
  endfunction

  // Location below the control boundary belongs to the clock/control window.
  function automatic logic in_ctrl_window(input int unsigned loc, input int unsigned ctrl_locs);
    return loc < ctrl_locs;
  endfunction

  // Whole location is read-only.
  function automatic logic loc_locked(input int unsigned loc, input int unsigned lo,
                                      input int unsigned hi);
    return (loc >= lo) && (loc <= hi);
  endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int unsigned AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_s,
  input  logic [AW-1:0] ad_s,
  output logic [AW-1:0] addr_q,
  output logic          as_fall,
  output logic          as_rise
);
  logic as_d;

  assign as_fall = as_d & ~as_s;
  assign as_rise = ~as_d & as_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_d   <= 1'b0;
      addr_q <= '0;
    end else begin
      as_d <= as_s;
      if (as_rise)      addr_q <= '0;
      else if (as_fall) addr_q <= ad_s;
    end
  end
endmodule

// File: rtl/mbus_access.sv
module mbus_access
  import mbus_pkg::*;
#(
  parameter int unsigned AW        = 7,
  parameter int unsigned DW        = 8,
  parameter int unsigned LOCK_LO   = 12,
  parameter int unsigned LOCK_HI   = 13,
  parameter int unsigned PART_LOC  = 10,
  parameter logic [DW-1:0] PART_MASK = 8'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mot,
  input  logic          ds_s,
  input  logic          rw_s,
  input  logic          sel_s,
  input  logic [DW-1:0] ad_s,
  input  logic [AW-1:0] addr,
  output logic          rd_go,
  output logic          wr_fall,
  output logic          rd_busy,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_wmask
);
  logic          rd_lvl, rd_lvl_d, wr_lvl, wr_lvl_d, sel_d;
  logic [DW-1:0] ad_d;

  assign rd_lvl  = rd_level(mot, ds_s, rw_s);
  assign wr_lvl  = wr_level(mot, ds_s, rw_s);
  assign rd_go   = rd_lvl & ~rd_lvl_d & sel_s;
  assign wr_fall = wr_lvl_d & ~wr_lvl & sel_d
                   & ~loc_locked(int'(addr), LOCK_LO, LOCK_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lvl_d  <= 1'b0;
      wr_lvl_d  <= 1'b0;
      sel_d     <= 1'b0;
      ad_d      <= '0;
      rd_busy   <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_wmask <= '0;
    end else begin
      rd_lvl_d <= rd_lvl;
      wr_lvl_d <= wr_lvl;
      sel_d    <= sel_s;
      ad_d     <= ad_s;
      reg_rd   <= rd_go;
      rd_busy  <= rd_go | (rd_busy & rd_lvl & sel_s);
      reg_wr   <= wr_fall;
      if (wr_fall) begin
        reg_wdata <= ad_d;
        reg_wmask <= (int'(addr) == PART_LOC) ? PART_MASK : '1;
      end
    end
  end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbus_pkg::*;
#(
  parameter int unsigned AW          = 7,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_LOCS   = 14,
  parameter int unsigned LOCK_LO     = 12,
  parameter int unsigned LOCK_HI     = 13,
  parameter int unsigned PART_LOC    = 10,
  parameter logic [DW-1:0] PART_MASK = 8'h7F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mot_sel,
  input  logic          host_rst_n,
  input  logic          pwr_fail,
  input  logic          cs_n,
  input  logic          as_strb,
  input  logic          ds_pin,
  input  logic          rw_pin,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_wmask,
  input  logic [DW-1:0] reg_rdata,
  output logic          loc_is_ctrl,
  output logic          loc_is_ram
);
  // Control bank order: host_rst_n, pwr_fail, cs_n, as, ds, rw
  localparam int unsigned CW = 6;
  localparam logic [CW-1:0] CTRL_IDLE = 6'b011001;

  logic [CW-1:0] ctrl_s;
  logic [DW-1:0] ad_s;
  logic          host_ok_s, pf_s, cs_n_s, as_s, ds_s, rw_s;
  logic          sel_ok, rd_go, wr_fall, as_fall, as_rise, rd_busy;

  mbus_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n),
    .d({host_rst_n, pwr_fail, cs_n, as_strb, ds_pin, rw_pin}),
    .q(ctrl_s)
  );

  mbus_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ad (
    .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s)
  );

  assign {host_ok_s, pf_s, cs_n_s, as_s, ds_s, rw_s} = ctrl_s;
  assign sel_ok = ~cs_n_s & ~pf_s & host_ok_s;

  mbus_addr_latch #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .as_s(as_s), .ad_s(ad_s[AW-1:0]),
    .addr_q(reg_addr), .as_fall(as_fall), .as_rise(as_rise)
  );

  mbus_access #(
    .AW(AW), .DW(DW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI),
    .PART_LOC(PART_LOC), .PART_MASK(PART_MASK)
  ) u_access (
    .clk(clk), .rst_n(rst_n), .mot(mot_sel), .ds_s(ds_s), .rw_s(rw_s),
    .sel_s(sel_ok), .ad_s(ad_s), .addr(reg_addr),
    .rd_go(rd_go), .wr_fall(wr_fall), .rd_busy(rd_busy),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_wmask(reg_wmask)
  );

  assign ad_oe       = rd_busy;
  assign ad_out      = rd_busy ? reg_rdata : '0;
  assign loc_is_ctrl = in_ctrl_window(int'(reg_addr), CTRL_LOCS);
  assign loc_is_ram  = ~loc_is_ctrl;
endmodule

// File: rtl/mbus_checker.sv
module mbus_checker #(
  parameter int unsigned AW        = 7,
  parameter int unsigned DW        = 8,
  parameter int unsigned LOCK_LO   = 12,
  parameter int unsigned LOCK_HI   = 13,
  parameter int unsigned PART_LOC  = 10,
  parameter logic [DW-1:0] PART_MASK = 8'h7F
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          host_rst_n,
  input logic          ad_oe,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wmask,
  input logic          loc_is_ctrl,
  input logic          loc_is_ram,
  input logic          sel_ok
);
  p_rd_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_rd_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> ad_oe);

  p_oe_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> $past(sel_ok));

  p_ro_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (int'(reg_addr) != LOCK_LO && int'(reg_addr) != LOCK_HI));

  p_part_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_addr) == PART_LOC) |-> reg_wmask == PART_MASK);

  p_pf_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && $past(pwr_fail) && $past(pwr_fail, 2) && $past(pwr_fail, 3)
     && $past(pwr_fail, 4)) |-> (!reg_rd && !reg_wr && !ad_oe));

  p_host_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rst_n && !$past(host_rst_n) && !$past(host_rst_n, 2)
     && !$past(host_rst_n, 3) && !$past(host_rst_n, 4)) |-> (!reg_rd && !reg_wr && !ad_oe));

  p_region_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({loc_is_ctrl, loc_is_ram}));
endmodule

bind mux_bus_slave mbus_checker #(
  .AW(AW), .DW(DW), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI),
  .PART_LOC(PART_LOC), .PART_MASK(PART_MASK)
) u_mbus_checker (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .host_rst_n(host_rst_n),
  .ad_oe(ad_oe), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wmask(reg_wmask), .loc_is_ctrl(loc_is_ctrl), .loc_is_ram(loc_is_ram),
  .sel_ok(sel_ok)
);

// File: tb/tb_mux_bus_slave.sv
`timescale 1ns/1ps
module tb_mux_bus_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mot_sel = 1'b1, host_rst_n = 1'b1, pwr_fail = 1'b0, cs_n = 1'b1;
  logic as_strb = 1'b0, ds_pin = 1'b0, rw_pin = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out, reg_wdata, reg_wmask, reg_rdata;
  logic [6:0] reg_addr;
  logic ad_oe, reg_rd, reg_wr, loc_is_ctrl, loc_is_ram;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd, last_wm;

  always #2.5 clk = ~clk;

  mux_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .mot_sel(mot_sel), .host_rst_n(host_rst_n),
    .pwr_fail(pwr_fail), .cs_n(cs_n), .as_strb(as_strb), .ds_pin(ds_pin),
    .rw_pin(rw_pin), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .loc_is_ctrl(loc_is_ctrl),
    .loc_is_ram(loc_is_ram)
  );

  // Register-file model: read data is a fixed scramble of the location.
  assign reg_rdata = {1'b0, reg_addr} ^ 8'h5A;

  always @(negedge clk) begin
    if (reg_rd) rd_cnt++;
    if (reg_wr) begin
      wr_cnt++;
      last_wa = reg_addr;
      last_wd = reg_wdata;
      last_wm = reg_wmask;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rexp(input logic [6:0] a);
    return {1'b0, a} ^ 8'h5A;
  endfunction

  task automatic set_mode(input logic m);
    mot_sel = m;
    ds_pin  = m ? 1'b0 : 1'b1;
    rw_pin  = 1'b1;
    cyc(6);
  endtask

  task automatic put_addr(input logic [7:0] a);
    ad_in = a; as_strb = 1'b1; cyc(4);
    as_strb = 1'b0; cyc(4);
  endtask

  task automatic t_reset;
    chk("R3 reset oe", ad_oe, 0);
    chk("R1 reset addr", reg_addr, 0);
    chk("R12 reset no rd", rd_cnt, 0);
  endtask

  task automatic t_addr_capture;
    put_addr(8'h85);
    chk("R1 bit7 ignored", reg_addr, 7'h05);
    as_strb = 1'b1; cyc(5);
    chk("R2 rise clears", reg_addr, 0);
    as_strb = 1'b0; cyc(4);
  endtask

  task automatic t_moto_read(input logic [6:0] a, input int hold, input string req);
    int r0 = rd_cnt;
    put_addr({1'b0, a});
    cs_n = 1'b0; rw_pin = 1'b1; ds_pin = 1'b1; cyc(hold);
    chk({req, " oe"}, ad_oe, 1);
    chk({req, " data"}, ad_out, rexp(a));
    ds_pin = 1'b0; cyc(6);
    chk({req, " released"}, ad_oe, 0);
    chk("R12 one pulse", rd_cnt - r0, 1);
    cs_n = 1'b1; cyc(3);
  endtask

  task automatic t_moto_write(input logic [6:0] a, input logic [7:0] d,
                              input int exp_n, input logic [7:0] exp_m, input string req);
    int w0 = wr_cnt;
    put_addr({1'b0, a});
    cs_n = 1'b0; rw_pin = 1'b0; ad_in = d; ds_pin = 1'b1; cyc(5);
    ds_pin = 1'b0; cyc(1); ad_in = 8'hEE; cyc(6);
    chk({req, " count"}, wr_cnt - w0, exp_n);
    if (exp_n == 1) begin
      chk({req, " addr"}, last_wa, a);
      chk({req, " data"}, last_wd, d);
      chk({req, " mask"}, last_wm, exp_m);
    end
    rw_pin = 1'b1; cs_n = 1'b1; cyc(3);
  endtask

  task automatic t_intel_read(input logic [6:0] a);
    int r0 = rd_cnt;
    put_addr({1'b0, a});
    cs_n = 1'b0; ds_pin = 1'b0; cyc(8);
    chk("R5 oe", ad_oe, 1);
    chk("R5 data", ad_out, rexp(a));
    ds_pin = 1'b1; cyc(6);
    chk("R5 released", ad_oe, 0);
    chk("R5 one pulse", rd_cnt - r0, 1);
    cs_n = 1'b1; cyc(3);
  endtask

  task automatic t_intel_write(input logic [6:0] a, input logic [7:0] d);
    int w0 = wr_cnt;
    put_addr({1'b0, a});
    cs_n = 1'b0; ad_in = d; rw_pin = 1'b0; cyc(5);
    rw_pin = 1'b1; cyc(1); ad_in = 8'h11; cyc(6);
    chk("R6 count", wr_cnt - w0, 1);
    chk("R6 data", last_wd, d);
    chk("R6 addr", last_wa, a);
    cs_n = 1'b1; cyc(3);
  endtask

  // Access attempt with one blocking condition applied by the caller.
  task automatic t_blocked(input string req, input logic [6:0] a);
    int r0 = rd_cnt, w0 = wr_cnt;
    put_addr({1'b0, a});
    chk({req, " addr latched"}, reg_addr, a);
    rw_pin = 1'b1; ds_pin = 1'b1; cyc(8);
    chk({req, " no oe"}, ad_oe, 0);
    ds_pin = 1'b0; cyc(4);
    rw_pin = 1'b0; ds_pin = 1'b1; cyc(5); ds_pin = 1'b0; cyc(6);
    rw_pin = 1'b1;
    chk({req, " no rd"}, rd_cnt - r0, 0);
    chk({req, " no wr"}, wr_cnt - w0, 0);
    cyc(3);
  endtask

  task automatic t_region(input logic [6:0] a, input logic c);
    put_addr({1'b0, a});
    chk("R11 ctrl", loc_is_ctrl, c);
    chk("R11 ram", loc_is_ram, !c);
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc(6);
        t_reset();
        set_mode(1'b1);
        t_addr_capture();
        t_moto_read(7'd14, 8, "R3");
        t_moto_read(7'd12, 40, "R12");
        t_moto_write(7'd20, 8'hA7, 1, 8'hFF, "R4");
        t_moto_write(7'd10, 8'hC3, 1, 8'h7F, "R10 partial");
        t_moto_write(7'd12, 8'h33, 0, 8'hFF, "R10 locked12");
        t_moto_write(7'd13, 8'h44, 0, 8'hFF, "R10 locked13");
        cs_n = 1'b1;
        t_blocked("R7", 7'd30);
        cs_n = 1'b0; pwr_fail = 1'b1; cyc(6);
        t_blocked("R8", 7'd31);
        pwr_fail = 1'b0; host_rst_n = 1'b0; cyc(6);
        t_blocked("R9", 7'd32);
        host_rst_n = 1'b1; cs_n = 1'b1; cyc(6);
        set_mode(1'b0);
        t_intel_read(7'd100);
        t_intel_write(7'd127, 8'h5C);
        t_region(7'd13, 1'b1);
        t_region(7'd14, 1'b0);
        t_region(7'd127, 1'b0);
        t_region(7'd0, 1'b1);
      end
      begin
        cyc(100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule